// File: doc/BRIEF.md
# NAND Read Pointer and Command Front End

This block sits on the device side of an 8-bit multiplexed flash bus. Each rising edge of the active-low write strobe latches one byte. The byte is a command when the command-latch input is high, an address when the address-latch input is high, and data otherwise. Three pointer commands choose which part of the 528-byte page a read starts in: the first 256-byte half, the second 256-byte half, or the 16-byte spare area. Four address bytes then give the start column and the 18-bit row. The row is made of a 5-bit page and a 13-bit block. The fourth address byte starts an internal page fetch, and the ready flag drops for a programmable number of clock cycles.

Once ready, each read-strobe pulse presents the byte at the current column and then moves one column on. When the column passes 527, the row increments and a new fetch begins. The next page starts at column 512 if the spare area was selected, and at column 0 otherwise. The abort command cancels any read in progress, points back to the first half and holds the block busy for a short reset time. The cell array is stood in for by a computed page store, so that any row can be read back without any storage.

Top module: `nand_ptr_front`

## Requirements
- R1: A page has 528 columns (0 to 527). The row is 18 bits: bits [4:0] select the page within a block and bits [17:5] select the block. The internal column never leaves the range 0 to 527.
- R2: Command 0x00 sets the start to column 0 plus the first address byte. Command 0x01 sets it to 256 plus that byte. Command 0x50 sets it to 512 plus the low 4 bits of that byte.
- R3: In an address sequence, the second byte is row[7:0], the third is row[15:8] and bits [1:0] of the fourth are row[17:16]. The fetch starts on the fourth byte. Further consecutive address bytes are ignored. A new sequence begins with the first address byte that follows a command byte, a data byte or a read strobe.
- R4: The byte presented for row r and column c is r[7:0] ^ r[15:8] ^ r[17:16] ^ c[7:0] ^ c[9:8], where the 2-bit terms are zero-extended.
- R5: Each rising edge of the read strobe while ready advances the column by one. When the column passes 527, the row increments (modulo 2^18), the column becomes 512 for a spare-area read and 0 otherwise, and a new fetch begins.
- R6: The spare-area pointer (0x50) stays in force for later address sequences until a 0x00 or 0xFF command is received. The 0x01 pointer applies to a single address sequence, after which the pointer returns to the first half.
- R7: The ready output goes low within three clock cycles of the write strobe rising on the fourth address byte. It stays low for READ_CYCLES cycles and then returns high.
- R8: While ready is low, read strobes do not move the column, the output enable stays low, and every byte other than 0xFF is ignored.
- R9: The output enable is high only when a read is active, ready is high and the read strobe is low.
- R10: Command 0xFF, which is accepted even while busy, ends the active read, points back to the first half, and holds ready low for RST_CYCLES cycles.
- R11: Data bytes and command codes other than 0x00, 0x01, 0x50 and 0xFF leave the column, the row and the pointer unchanged.
- R12: After reset, ready is high, the output enable is low and the pointer is the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the strobes are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | High: the latched byte is a command |
| ale | input | 1 | High: the latched byte is an address |
| we_n | input | 1 | Write strobe; the byte is latched on its rising edge |
| re_n | input | 1 | Read strobe; low presents data, the rising edge advances the column |
| io_in | input | 8 | Byte driven by the host |
| io_out | output | 8 | Byte at the current row and column |
| io_oe | output | 1 | Drive enable for io_out |
| rdy | output | 1 | High when ready, low while fetching or resetting |

## Verification
Two functions can land in the same window: a page fetch that is still counting, and either a read strobe or an abort command from the host. The bench pulses the read strobe while ready is low. It checks that the output enable stays low and that the first byte read after ready returns reflects the start column, not an advanced one. It also issues 0xFF partway through a fetch. It checks that ready returns within the short reset time, not the full fetch time, that no data is driven afterwards, and that the next address sequence reads from the first half even though the spare area had been selected. The column wrap is provoked from both the second-half and the spare pointers, including the wrap of the last row to row 0.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

   typedef enum logic [1:0] {
      RGN_LO    = 2'd0,
      RGN_HI    = 2'd1,
      RGN_SPARE = 2'd2
   } region_e;

   typedef enum logic [1:0] {
      CYC_NONE = 2'd0,
      CYC_CMD  = 2'd1,
      CYC_ADDR = 2'd2,
      CYC_DATA = 2'd3
   } cyc_e;

   localparam logic [7:0] OP_PTR_LO    = 8'h00;
   localparam logic [7:0] OP_PTR_HI    = 8'h01;
   localparam logic [7:0] OP_PTR_SPARE = 8'h50;
   localparam logic [7:0] OP_ABORT     = 8'hFF;

   // Stand-in page store: a byte folded out of row and column.
   function automatic logic [7:0] page_byte(input logic [23:0] r, input logic [15:0] c);
      return r[7:0] ^ r[15:8] ^ r[23:16] ^ c[7:0] ^ c[15:8];
   endfunction

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync
   import nand_fe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic [7:0] io_in,
   output cyc_e       cyc,
   output logic [7:0] lat_byte,
   output logic       re_rise
);
   logic we_q, re_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q     <= 1'b1;
         re_q     <= 1'b1;
         cyc      <= CYC_NONE;
         lat_byte <= '0;
         re_rise  <= 1'b0;
      end else begin
         we_q    <= we_n;
         re_q    <= re_n;
         re_rise <= re_n & ~re_q;
         if (we_n && !we_q) begin
            lat_byte <= io_in;
            cyc      <= cle ? CYC_CMD : (ale ? CYC_ADDR : CYC_DATA);
         end else begin
            cyc <= CYC_NONE;
         end
      end
   end

   assert_one_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != CYC_NONE) |=> (cyc == CYC_NONE));

endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
   import nand_fe_pkg::*;
#(
   parameter int ROW_BITS    = 18,
   parameter int SPARE_BYTES = 16,
   localparam int HALF_BYTES = 256,
   localparam int MAIN_BYTES = 2 * HALF_BYTES,
   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
   localparam int COL_W      = $clog2(PAGE_BYTES),
   localparam int SPARE_W    = $clog2(SPARE_BYTES)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  cyc_e                cyc,
   input  logic [7:0]          lat_byte,
   input  logic                re_rise,
   input  logic                busy,
   output logic                start_fetch,
   output logic [COL_W-1:0]    start_col,
   output logic [ROW_BITS-1:0] start_row,
   output logic                start_spare,
   output logic                abort
);
   region_e     ptr;
   logic [2:0]  addr_cnt, idx;
   logic        seq_open;
   logic [7:0]  off_q;
   logic [15:0] row_acc;
   logic [COL_W-1:0] base_col;

   always_comb idx = seq_open ? addr_cnt : 3'd0;

   always_comb begin
      case (ptr)
         RGN_HI:    base_col = COL_W'(HALF_BYTES) + COL_W'(off_q);
         RGN_SPARE: base_col = COL_W'(MAIN_BYTES) + COL_W'(off_q[SPARE_W-1:0]);
         default:   base_col = COL_W'(off_q);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr         <= RGN_LO;
         addr_cnt    <= '0;
         seq_open    <= 1'b0;
         off_q       <= '0;
         row_acc     <= '0;
         start_fetch <= 1'b0;
         start_col   <= '0;
         start_row   <= '0;
         start_spare <= 1'b0;
         abort       <= 1'b0;
      end else begin
         start_fetch <= 1'b0;
         abort       <= 1'b0;
         case (cyc)
            CYC_CMD: begin
               seq_open <= 1'b0;
               if (lat_byte == OP_ABORT) begin
                  ptr   <= RGN_LO;
                  abort <= 1'b1;
               end else if (!busy) begin
                  if (lat_byte == OP_PTR_LO)    ptr <= RGN_LO;
                  if (lat_byte == OP_PTR_HI)    ptr <= RGN_HI;
                  if (lat_byte == OP_PTR_SPARE) ptr <= RGN_SPARE;
               end
            end
            CYC_ADDR: if (!busy) begin
               seq_open <= 1'b1;
               if (idx < 3'd4) addr_cnt <= idx + 3'd1;
               case (idx)
                  3'd0: off_q          <= lat_byte;
                  3'd1: row_acc[7:0]   <= lat_byte;
                  3'd2: row_acc[15:8]  <= lat_byte;
                  3'd3: begin
                     start_fetch <= 1'b1;
                     start_row   <= {lat_byte[ROW_BITS-17:0], row_acc};
                     start_col   <= base_col;
                     start_spare <= (ptr == RGN_SPARE);
                     if (ptr == RGN_HI) ptr <= RGN_LO;
                  end
                  default: ;
               endcase
            end
            CYC_DATA: seq_open <= 1'b0;
            default:  if (re_rise) seq_open <= 1'b0;
         endcase
      end
   end

   assert_abort_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_CMD && lat_byte == OP_ABORT) |=> (ptr == RGN_LO && abort));

   assert_fetch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_fetch |=> !start_fetch);

endmodule

// File: rtl/nand_col_seq.sv
module nand_col_seq #(
   parameter int ROW_BITS    = 18,
   parameter int PAGE_BYTES  = 528,
   parameter int SPARE_START = 512,
   parameter int READ_CYCLES = 6250,
   parameter int RST_CYCLES  = 1500,
   localparam int COL_W      = $clog2(PAGE_BYTES),
   localparam int T_MAX      = (READ_CYCLES > RST_CYCLES) ? READ_CYCLES : RST_CYCLES,
   localparam int TW         = $clog2(T_MAX + 1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_fetch,
   input  logic [COL_W-1:0]    start_col,
   input  logic [ROW_BITS-1:0] start_row,
   input  logic                start_spare,
   input  logic                abort,
   input  logic                re_rise,
   output logic [COL_W-1:0]    col,
   output logic [ROW_BITS-1:0] row,
   output logic                busy,
   output logic                active
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

   logic [TW-1:0] timer;
   logic          spare_q;

   always_comb busy = (timer != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer   <= '0;
         col     <= '0;
         row     <= '0;
         active  <= 1'b0;
         spare_q <= 1'b0;
      end else if (abort) begin
         active <= 1'b0;
         timer  <= TW'(RST_CYCLES);
      end else if (start_fetch) begin
         col     <= start_col;
         row     <= start_row;
         spare_q <= start_spare;
         active  <= 1'b1;
         timer   <= TW'(READ_CYCLES);
      end else if (busy) begin
         timer <= timer - 1'b1;
      end else if (re_rise && active) begin
         if (col == LAST_COL) begin
            col   <= spare_q ? COL_W'(SPARE_START) : '0;
            row   <= row + 1'b1;
            timer <= TW'(READ_CYCLES);
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      col <= LAST_COL);

   assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(col));

   assert_fetch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_fetch && !abort) |=> busy);

   assert_wrap_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (re_rise && active && !busy && !abort && !start_fetch && col == LAST_COL)
      |=> (busy && row == $past(row) + 1'b1 &&
           (col == '0 || (spare_q && col == COL_W'(SPARE_START)))));

endmodule

// File: rtl/nand_ptr_front.sv
module nand_ptr_front
   import nand_fe_pkg::*;
#(
   parameter int ROW_BITS    = 18,
   parameter int SPARE_BYTES = 16,
   parameter int READ_CYCLES = 6250,
   parameter int RST_CYCLES  = 1500,
   parameter bit OUT_REG     = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic [7:0] io_in,
   output logic [7:0] io_out,
   output logic       io_oe,
   output logic       rdy
);
   localparam int MAIN_BYTES = 512;
   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
   localparam int COL_W      = $clog2(PAGE_BYTES);

   if (ROW_BITS < 17 || ROW_BITS > 24) begin : g_bad_row
      $error("ROW_BITS must lie in 17..24");
   end
   if (SPARE_BYTES < 2 || SPARE_BYTES > 256 || (SPARE_BYTES & (SPARE_BYTES - 1)) != 0) begin : g_bad_spare
      $error("SPARE_BYTES must be a power of two in 2..256");
   end
   if (READ_CYCLES < 1 || RST_CYCLES < 1) begin : g_bad_time
      $error("READ_CYCLES and RST_CYCLES must be at least 1");
   end

   cyc_e                cyc;
   logic [7:0]          lat_byte;
   logic                re_rise, busy, active;
   logic                start_fetch, start_spare, abort;
   logic [COL_W-1:0]    start_col, col;
   logic [ROW_BITS-1:0] start_row, row;
   logic [7:0]          cell_byte;

   nand_strobe_sync i_sync (
      .clk, .rst_n, .cle, .ale, .we_n, .re_n, .io_in,
      .cyc, .lat_byte, .re_rise
   );

   nand_cmd_decode #(.ROW_BITS(ROW_BITS), .SPARE_BYTES(SPARE_BYTES)) i_dec (
      .clk, .rst_n, .cyc, .lat_byte, .re_rise, .busy,
      .start_fetch, .start_col, .start_row, .start_spare, .abort
   );

   nand_col_seq #(
      .ROW_BITS(ROW_BITS), .PAGE_BYTES(PAGE_BYTES), .SPARE_START(MAIN_BYTES),
      .READ_CYCLES(READ_CYCLES), .RST_CYCLES(RST_CYCLES)
   ) i_seq (
      .clk, .rst_n, .start_fetch, .start_col, .start_row, .start_spare,
      .abort, .re_rise, .col, .row, .busy, .active
   );

   always_comb cell_byte = page_byte(24'(row), 16'(col));

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) io_out <= '0;
         else        io_out <= cell_byte;
      end
   end else begin : g_out_comb
      always_comb io_out = cell_byte;
   end

   always_comb begin
      rdy   = !busy;
      io_oe = active && !busy && !re_n;
   end

   assert_quiet_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !io_oe);

endmodule

// File: tb/test_nand_ptr_front.sv
module test_nand_ptr_front;
   import nand_fe_pkg::*;

   localparam int READ_CY = 60;
   localparam int RST_CY  = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
   logic [7:0] io_in = '0;
   logic [7:0] io_out;
   logic       io_oe, rdy;

   int checks = 0;
   int fails  = 0;
   int m_rgn  = 0;   // bench pointer model: 0 low half, 1 high half, 2 spare

   always #2 clk = ~clk;   // 250 MHz

   nand_ptr_front #(.READ_CYCLES(READ_CY), .RST_CYCLES(RST_CY)) i_nand_ptr_front (
      .clk, .rst_n, .cle, .ale, .we_n, .re_n, .io_in, .io_out, .io_oe, .rdy
   );

   // {command, offset, read count, row}
   localparam logic [39:0] VEC [5] = '{
      {8'h00, 8'h10, 6'd4,  18'h00005},
      {8'h01, 8'hFE, 6'd4,  18'h00123},
      {8'h50, 8'h0E, 6'd4,  18'h3FFFF},
      {8'h01, 8'hFF, 6'd20, 18'h00040},
      {8'h00, 8'hFF, 6'd3,  18'h01000}
   };

   function automatic logic [7:0] pat(input logic [17:0] r, input int c);
      logic [9:0] cc;
      cc = 10'(c);
      return r[7:0] ^ r[15:8] ^ {6'd0, r[17:16]} ^ cc[7:0] ^ {6'd0, cc[9:8]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic a, input logic [7:0] b);
      @(negedge clk);
      cle = c; ale = a; io_in = b; we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (3) @(negedge clk);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic addr4(input logic [7:0] off, input logic [17:0] r);
      wr(0, 1, off);
      wr(0, 1, r[7:0]);
      wr(0, 1, r[15:8]);
      wr(0, 1, {6'd0, r[17:16]});
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      while (!rdy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (!rdy) chk("R7 ready timeout", 32'(rdy), 1);
   endtask

   task automatic read_chk(input string req, input logic [7:0] exp);
      int n;
      wait_rdy(n);
      @(negedge clk);
      re_n = 1'b0;
      repeat (2) @(negedge clk);
      chk({req, " oe"}, 32'(io_oe), 1);
      chk(req, 32'(io_out), 32'(exp));
      re_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_read(input bit use_cmd, input logic [7:0] cmd, input logic [7:0] off,
                           input logic [17:0] r0, input int nbytes, input string req);
      int c;
      bit spare;
      logic [17:0] r;
      if (use_cmd) begin
         wr(1, 0, cmd);
         if (cmd == 8'h00) m_rgn = 0;
         if (cmd == 8'h01) m_rgn = 1;
         if (cmd == 8'h50) m_rgn = 2;
      end
      c = (m_rgn == 0) ? int'(off) : (m_rgn == 1) ? 256 + int'(off) : 512 + int'(off[3:0]);
      spare = (m_rgn == 2);
      if (m_rgn == 1) m_rgn = 0;
      r = r0;
      addr4(off, r0);
      for (int k = 0; k < nbytes; k++) begin
         read_chk((k == 0) ? {req, " R2 start"} : {req, " R5 step"}, pat(r, c));
         c++;
         if (c == 528) begin
            c = spare ? 512 : 0;
            r = r + 1'b1;
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk("R12 rdy", 32'(rdy), 1);
      chk("R12 oe", 32'(io_oe), 0);
      re_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 no read active", 32'(io_oe), 0);
      re_n = 1'b1;
      repeat (3) @(negedge clk);
      run_read(0, 8'h00, 8'h20, 18'h00009, 2, "R12 ptr");

      // table walk: R2, R4, R5 (including wrap of row 3FFFF to 0)
      foreach (VEC[i])
         run_read(1, VEC[i][39:32], VEC[i][31:24], VEC[i][17:0], int'(VEC[i][23:18]), "R4 vec");

      // R6: spare pointer sticky, 0x00 restores
      run_read(1, 8'h50, 8'h02, 18'h00100, 1, "R6 set");
      run_read(0, 8'h00, 8'h05, 18'h00101, 1, "R6 sticky");
      run_read(1, 8'h00, 8'h05, 18'h00101, 1, "R6 cleared");
      // R6: high-half pointer for one sequence only
      run_read(1, 8'h01, 8'h04, 18'h00022, 1, "R6 hi");
      run_read(0, 8'h00, 8'h04, 18'h00022, 1, "R6 hi once");

      // R7 / R8: busy window and strobes during it
      wr(1, 0, 8'h00);
      addr4(8'h30, 18'h00055);
      chk("R7 busy", 32'(rdy), 0);
      re_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 oe while busy", 32'(io_oe), 0);
      re_n = 1'b1;
      repeat (3) @(negedge clk);
      wr(0, 0, 8'h77);
      re_n = 1'b0;
      repeat (2) @(negedge clk);
      re_n = 1'b1;
      wait_rdy(n);
      chk("R7 busy length", 32'(n > 20 && n < READ_CY), 1);
      read_chk("R8 no advance", pat(18'h00055, 8'h30));

      // R3: fifth address ignored
      wr(1, 0, 8'h00);
      m_rgn = 0;
      addr4(8'h40, 18'h00066);
      wait_rdy(n);
      wr(0, 1, 8'h99);
      read_chk("R3 fifth ignored", pat(18'h00066, 'h40));
      read_chk("R3 next col", pat(18'h00066, 'h41));
      // R11: data and unknown command bytes ignored
      wr(0, 0, 8'hA5);
      read_chk("R11 data byte", pat(18'h00066, 'h42));
      wr(1, 0, 8'h33);
      read_chk("R11 other cmd", pat(18'h00066, 'h43));

      // R10: abort during fetch
      wr(1, 0, 8'h50);
      addr4(8'h01, 18'h00077);
      wr(1, 0, 8'hFF);
      m_rgn = 0;
      wait_rdy(n);
      chk("R10 short reset", 32'(n <= RST_CY + 4), 1);
      re_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 read ended", 32'(io_oe), 0);
      re_n = 1'b1;
      repeat (3) @(negedge clk);
      run_read(0, 8'h00, 8'h06, 18'h00078, 1, "R10 ptr home");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule